// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation converter. It steps through a fixed frame of fifteen clock periods. The first three periods track the analog input while the comparator settles. The remaining twelve each test one bit of a trial word, from the top bit down. The trial word drives the switch array. A single comparator bit, high when the input is above the current trial level, decides whether each tested bit is kept. At the end of the last period, the finished code moves into an output register that holds it for the whole of the next frame.

An active-low start input selects the operating mode. If it is held low, frames run back to back. If it is high at the end of period 1, the sequencer parks in track with the data-ready flag still high. A later low on start resumes the frame directly at period 3. The result leaves the block as two groups, a high group and a low group. Each group has its own active-low enable and floats when disabled. A debug output shows the current period number.

Top module: `sar_seq`

## Requirements
- R1: With start_n held low, frames run back to back and data_rdy rises once every 15 clock cycles.
- R2: track_en is high and trial is all zeros in periods 1 to 3 and while parked. track_en is low in periods 4 to 15.
- R3: In period 4, trial equals only bit 11 set (0x800).
- R4: Periods 4 to 15 test bits 11 down to 0, one bit per period. Each period sets the bit under test on top of the earlier decisions and keeps it only if cmp_hi is high. With cmp_hi = (code >= trial), the result equals the code.
- R5: The output register changes only at the rising edge that ends period 15. It holds its value through the following frame and while parked.
- R6: data_rdy rises at the edge that starts period 1. If the frame continues, data_rdy falls at the edge that starts period 2.
- R7: start_n is sampled at the edge that ends period 1. If it is high, the sequencer parks: period reads 0, data_rdy stays high and the result is held.
- R8: While parked, an edge that samples start_n low moves the sequencer to period 3 and clears data_rdy.
- R9: start_n has no effect during periods 2 to 15.
- R10: When oe_hi_n is high, dout bits 11 to 4 are high impedance. When oe_lo_n is high, dout bits 3 to 0 are high impedance. When an enable is low, its group drives the result bits.
- R11: A synchronous active-high reset gives period 0 (parked), data_rdy low, result zero, trial zero and track_en high.
- R12: period reads 0 while parked, and 1 to 15 for the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes occur on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Active-low start or continue request |
| cmp_hi | input | 1 | Comparator decision: high when the input is above the trial level |
| oe_hi_n | input | 1 | Active-low enable for result bits 11 to 4 |
| oe_lo_n | input | 1 | Active-low enable for result bits 3 to 0 |
| trial | output | 12 | Trial word for the switch array |
| track_en | output | 1 | High while the input is being tracked |
| data_rdy | output | 1 | Data-ready flag |
| dout | output | 12 | Result, driven per group or high impedance |
| period | output | 4 | Debug view of the current period (0 means parked) |

## Verification
A wrong period count shows first on the debug output. It then moves the data_rdy rising edge off its 15-cycle spacing, so a miscount is visible within one frame. A bit that is set or cleared in the wrong period changes the trial value seen in period 4, or produces a final code that differs from the ideal code. The mismatch appears at the next data_rdy rising edge, at most 15 cycles later. A start input decoded at the wrong time shows within one or two cycles, as the wrong period number or a data_rdy that is dropped or held when it should not be.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned SAR_BITS_DEF  = 12;
  localparam int unsigned TRACK_DEF     = 3;
  localparam int unsigned LO_GROUP_DEF  = 4;
endpackage

// File: rtl/sar_period_ctrl.sv
module sar_period_ctrl #(
  parameter int unsigned BITS  = 12,
  parameter int unsigned TRACK = 3,
  localparam int unsigned FRAME = TRACK + BITS,
  localparam int unsigned PW    = $clog2(FRAME + 1),
  localparam int unsigned BW    = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  output logic [PW-1:0] per_q,
  output logic          data_rdy,
  output logic          track_en,
  output logic          in_track,
  output logic          conv_go,
  output logic          decide,
  output logic          last,
  output logic [BW-1:0] bit_idx
);
  logic [PW-1:0] per_nx;

  always_comb begin
    if (per_q == '0)
      per_nx = start_n ? '0 : PW'(TRACK);
    else if (per_q == PW'(1))
      per_nx = start_n ? '0 : PW'(2);
    else if (per_q == PW'(FRAME))
      per_nx = PW'(1);
    else
      per_nx = per_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q    <= '0;
      data_rdy <= 1'b0;
      track_en <= 1'b1;
    end else begin
      per_q    <= per_nx;
      track_en <= (per_nx <= PW'(TRACK));
      if (per_q == PW'(FRAME))
        data_rdy <= 1'b1;
      else if ((per_q == '0 || per_q == PW'(1)) && !start_n)
        data_rdy <= 1'b0;
    end
  end

  assign in_track = (per_q <= PW'(TRACK));
  assign conv_go  = (per_q == PW'(TRACK));
  assign decide   = (per_q > PW'(TRACK));
  assign last     = (per_q == PW'(FRAME));
  assign bit_idx  = BW'(FRAME - int'(per_q));

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (per_q == PW'(FRAME)) |=> (per_q == PW'(1)));
  a_r6_rise_p1: assert property (@(posedge clk) disable iff (rst)
    $rose(data_rdy) |-> (per_q == PW'(1)));
  a_r8_resume: assert property (@(posedge clk) disable iff (rst)
    (per_q == '0 && !start_n) |=> (per_q == PW'(TRACK) && !data_rdy));
  a_r2_track: assert property (@(posedge clk) disable iff (rst)
    in_track |-> track_en);
  a_r7_park: assert property (@(posedge clk) disable iff (rst)
    (per_q == PW'(1) && start_n) |=> (per_q == '0 && data_rdy));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned BITS = 12,
  localparam int unsigned BW  = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_go,
  input  logic            decide,
  input  logic            last,
  input  logic            in_track,
  input  logic [BW-1:0]   bit_idx,
  input  logic            cmp_hi,
  output logic [BITS-1:0] trial_q,
  output logic [BITS-1:0] result_q
);
  localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] step;

  always_comb begin
    step = trial_q;
    for (int i = 0; i < BITS; i++) begin
      if (BW'(i) == bit_idx)
        step[i] = cmp_hi;
      else if (BW'(i + 1) == bit_idx)
        step[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q  <= '0;
      result_q <= '0;
    end else if (conv_go) begin
      trial_q <= MSB_ONLY;
    end else if (decide) begin
      if (last) begin
        trial_q  <= '0;
        result_q <= step;
      end else begin
        trial_q <= step;
      end
    end
  end

  a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
    conv_go |=> (trial_q == MSB_ONLY));
  a_r2_zero_trial: assert property (@(posedge clk) disable iff (rst)
    in_track |-> (trial_q == '0));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(result_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned BITS  = SAR_BITS_DEF,
  parameter int unsigned TRACK = TRACK_DEF,
  parameter int unsigned LO    = LO_GROUP_DEF,
  localparam int unsigned PW   = $clog2(TRACK + BITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_n,
  input  logic            cmp_hi,
  input  logic            oe_hi_n,
  input  logic            oe_lo_n,
  output logic [BITS-1:0] trial,
  output logic            track_en,
  output logic            data_rdy,
  output logic [BITS-1:0] dout,
  output logic [PW-1:0]   period
);
  localparam int unsigned BW = $clog2(BITS);

  logic          in_track, conv_go, decide, last;
  logic [BW-1:0] bit_idx;
  logic [BITS-1:0] result;

  sar_period_ctrl #(.BITS(BITS), .TRACK(TRACK)) u_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n), .per_q(period),
    .data_rdy(data_rdy), .track_en(track_en), .in_track(in_track),
    .conv_go(conv_go), .decide(decide), .last(last), .bit_idx(bit_idx)
  );

  sar_trial_reg #(.BITS(BITS)) u_trial (
    .clk(clk), .rst(rst), .conv_go(conv_go), .decide(decide), .last(last),
    .in_track(in_track), .bit_idx(bit_idx), .cmp_hi(cmp_hi),
    .trial_q(trial), .result_q(result)
  );

  assign dout[BITS-1:LO] = oe_hi_n ? 'z : result[BITS-1:LO];
  assign dout[LO-1:0]    = oe_lo_n ? 'z : result[LO-1:0];

  a_r2_conv_low: assert property (@(posedge clk) disable iff (rst)
    !in_track |-> !track_en);
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic clk = 1'b0;
  logic rst, start_n, oe_hi_n, oe_lo_n;
  logic [11:0] target;
  logic [11:0] trial;
  logic track_en, data_rdy, cmp_hi;
  logic [3:0] period;
  wire  [11:0] bus;
  int checks = 0, errors = 0, cyc = 0;
  logic [11:0] expq[$];
  logic [11:0] last_res = '0;
  bit fr_mode = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 12; g++) begin : g_pu
    pullup (bus[g]);
  end

  assign cmp_hi = (target >= trial);

  sar_seq u_dut (
    .clk(clk), .rst(rst), .start_n(start_n), .cmp_hi(cmp_hi),
    .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .trial(trial),
    .track_en(track_en), .data_rdy(data_rdy), .dout(bus), .period(period)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each data_rdy rising edge
  initial begin
    bit dr_prev = 0;
    int last_rise = -1;
    bit last_fr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (data_rdy && !dr_prev) begin
        chk(period == 4'd1, "R6 rise in period 1", period, 1);
        if (expq.size() == 0) chk(0, "R4 unexpected result", bus, 0);
        else begin
          last_res = expq.pop_front();
          chk(bus == last_res, "R4 result equals code", bus, last_res);
        end
        if (fr_mode && last_fr)
          chk(cyc - last_rise == 15, "R1 frame spacing", cyc - last_rise, 15);
        last_rise = cyc;
        last_fr = fr_mode;
      end
      dr_prev = data_rdy;
    end
  end

  task automatic single_shot(input logic [11:0] code);
    @(negedge clk);
    target = code;
    expq.push_back(code);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    chk(period == 4'd3 && !data_rdy, "R8 resume at period 3", {data_rdy, period}, 3);
    chk(track_en == 1'b1, "R2 track in period 3", track_en, 1);
    @(negedge clk);
    chk(trial == 12'h800, "R3 msb trial", trial, 12'h800);
    chk(track_en == 1'b0, "R2 hold in period 4", track_en, 0);
    repeat (3) @(negedge clk);
    start_n = 1'b0;                    // R9: pulse during period 7
    @(negedge clk);
    start_n = 1'b1;
    chk(period == 4'd8, "R9 start ignored mid frame", period, 8);
    repeat (7) @(negedge clk);
    chk(period == 4'd15, "R12 period 15", period, 15);
    @(negedge clk);
    chk(period == 4'd1 && data_rdy, "R6 ready in period 1", {data_rdy, period}, 17);
    @(negedge clk);
    chk(period == 4'd0 && data_rdy, "R7 parked with ready", {data_rdy, period}, 16);
    chk(trial == 12'h000 && track_en, "R2 parked track", trial, 0);
    repeat (5) @(negedge clk);
    chk(data_rdy && bus == code, "R5 R7 parked holds", bus, code);
  endtask

  initial begin
    logic [11:0] codes[7] = '{12'hFFF, 12'h800, 12'h001, 12'h555, 12'hAAA, 12'hFFE, 12'h7FF};
    rst = 1'b1; start_n = 1'b1; oe_hi_n = 1'b0; oe_lo_n = 1'b0; target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(period == 4'd0 && !data_rdy, "R11 reset parked", {data_rdy, period}, 0);
    chk(trial == 12'h000 && track_en, "R11 reset trial", trial, 0);
    chk(bus == 12'h000, "R11 reset result", bus, 0);

    single_shot(12'hA5C);
    single_shot(12'h000);

    oe_hi_n = 1'b1;
    @(negedge clk);
    chk(bus == 12'hFF0, "R10 high group floats", bus, 12'hFF0);
    oe_lo_n = 1'b1;
    @(negedge clk);
    chk(bus == 12'hFFF, "R10 both groups float", bus, 12'hFFF);
    oe_hi_n = 1'b0;
    @(negedge clk);
    chk(bus == 12'h00F, "R10 low group floats", bus, 12'h00F);
    oe_lo_n = 1'b0;

    // free-running
    @(negedge clk);
    fr_mode = 1;
    target = codes[0];
    expq.push_back(codes[0]);
    start_n = 1'b0;
    for (int i = 1; i < 7; i++) begin
      do @(negedge clk); while (period != 4'd2);
      chk(!data_rdy, "R6 ready falls in period 2", data_rdy, 0);
      chk(bus == last_res, "R5 held into next frame", bus, last_res);
      target = codes[i];
      expq.push_back(codes[i]);
    end
    do @(negedge clk); while (period != 4'd15);
    start_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(period == 4'd0 && data_rdy, "R7 park after free run", {data_rdy, period}, 16);
    chk(expq.size() == 0, "R4 all results seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule